// File: doc/BRIEF.md
# Modular Exponentiation Unit (LSB-first square-and-multiply)

This unit computes `base^exp mod modulus` for 32-bit unsigned operands over many clock cycles. A single-cycle `start_i` pulse captures the three operands. Then a sequencer walks the exponent from its lowest bit to its highest and hands every modular product to one shared multiplier. That multiplier reduces the product one bit at a time by the shift-add method, with up to two subtractions of the modulus per step.

The unit keeps two registers. The running result starts at 1 and the running square starts at the base. On a set exponent bit, the result is multiplied by the square first, and the square is updated afterwards. On every bit the square is replaced by its own square. The scan always covers all 32 exponent bits and never stops early. After the last bit, `done_o` pulses for one cycle and `result_o` presents the answer, which stays put until the next completion.

The caller guarantees `base_i < mod_i` and `mod_i >= 2`.

Top module: `modexp_rl`

## Requirements
- R1: While reset is asserted and after its release with no start, `done_o` is 0 and `result_o` is 0.
- R2: `done_o` goes high for exactly one cycle. It rises after the clock edge that comes 34*(32 + popcount(exp)) edges after the edge that sampled the accepted `start_i`. Each multiplication takes 34 cycles.
- R3: When `done_o` is high, `result_o` equals `base^exp mod modulus`, with every one of the 32 exponent bits (bit 0 through bit 31) taking part.
- R4: An exponent of 0 yields a result of 1.
- R5: An exponent of 2 yields `base*base mod modulus`, even though all 32 bit steps are still run.
- R6: A `start_i` pulse that arrives while a computation is in progress is ignored. The operands and result of the running job are unaffected.
- R7: `result_o` changes only in a cycle where `done_o` is high. Otherwise it holds its previous value.
- R8: Moduli close to 2^32 give correct results, because the intermediate sums of the multiplier do not overflow.
- R9: A `start_i` pulse given in the same cycle that `done_o` is high is accepted, so jobs can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; operands are sampled with it when idle |
| base_i | input | 32 | Base, already below the modulus |
| exp_i | input | 32 | Exponent |
| mod_i | input | 32 | Modulus, at least 2 |
| result_o | output | 32 | Last completed result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports depend on exact cycle placement: a request that lands in the one cycle where `done_o` is high, and a second request that lands in the middle of a multiplication. The stimulus times these pulses from a cycle-accurate reference model of the latency. The model predicts the completion cycle from the popcount of the exponent, so the bench can place a start exactly on the done cycle and another one deep inside a running job. Accumulator overflow only shows up with a modulus just under 2^32 and an exponent with all bits set. One job is built that way to push the interleaved sums to their largest values.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    // Sequencer states: a launch cycle and a wait phase for each product kind.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RGO   = 3'd1,
        ST_RWAIT = 3'd2,
        ST_SGO   = 3'd3,
        ST_SWAIT = 3'd4
    } seq_state_e;

endpackage

// File: rtl/modexp_mul.sv
// Interleaved shift-add modular multiplier: one multiplier bit per cycle,
// most significant first, at most two modulus subtractions per step.
module modexp_mul #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] m_i,
    output logic         done_o,
    output logic [W-1:0] prod_o
);

    localparam int CW = $clog2(W);
    localparam int AW = W + 2;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  x;
        logic [W-1:0]  y;
        logic [W-1:0]  m;
        logic [AW-1:0] acc;
    } mul_st_t;

    mul_st_t st_d, st_q;
    logic [AW-1:0] sum0, sum1, sum2, m_ext, y_ext;

    always_comb begin
        m_ext = {2'b00, st_q.m};
        y_ext = {2'b00, st_q.y};
        sum0  = {st_q.acc[AW-2:0], 1'b0} + (st_q.x[W-1] ? y_ext : '0);
        sum1  = (sum0 >= m_ext) ? (sum0 - m_ext) : sum0;
        sum2  = (sum1 >= m_ext) ? (sum1 - m_ext) : sum1;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(W - 1);
            st_d.x    = x_i;
            st_d.y    = y_i;
            st_d.m    = m_i;
            st_d.acc  = '0;
        end else if (st_q.busy) begin
            st_d.acc = sum2;
            st_d.x   = {st_q.x[W-2:0], 1'b0};
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign prod_o = st_q.acc[W-1:0];

    // R8: the partial product stays reduced between steps.
    assert_acc_below_mod_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> (st_q.acc < {2'b00, st_q.m}));

    // R2: the sequencer never relaunches a product in flight.
    assert_no_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.busy |-> !start_i);

    // R2: product completion is a single-cycle pulse.
    assert_mul_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

endmodule

// File: rtl/modexp_seq.sv
// Exponent scan control: LSB-first, result product before squaring.
module modexp_seq
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] exp_i,
    input  logic [W-1:0] mod_i,
    output logic         mul_start_o,
    output logic [W-1:0] mul_x_o,
    output logic [W-1:0] mul_y_o,
    output logic [W-1:0] mul_m_o,
    input  logic         mul_done_i,
    input  logic [W-1:0] mul_prod_i,
    output logic [W-1:0] result_o,
    output logic         done_o
);

    localparam int CW = $clog2(W);

    typedef struct packed {
        seq_state_e    state;
        logic [W-1:0]  res;
        logic [W-1:0]  sq;
        logic [W-1:0]  e;
        logic [W-1:0]  n;
        logic [CW-1:0] bitc;
        logic [W-1:0]  out;
        logic          done;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [W-1:0] e_next;

    always_comb begin
        mul_start_o = (st_q.state == ST_RGO) || (st_q.state == ST_SGO);
        mul_x_o     = (st_q.state == ST_RGO) ? st_q.res : st_q.sq;
        mul_y_o     = st_q.sq;
        mul_m_o     = st_q.n;
        e_next      = st_q.e >> 1;

        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.res   = W'(1);
                    st_d.sq    = base_i;
                    st_d.e     = exp_i;
                    st_d.n     = mod_i;
                    st_d.bitc  = '0;
                    st_d.state = exp_i[0] ? ST_RGO : ST_SGO;
                end
            end
            ST_RGO:   st_d.state = ST_RWAIT;
            ST_RWAIT: begin
                if (mul_done_i) begin
                    st_d.res   = mul_prod_i;
                    st_d.state = ST_SGO;
                end
            end
            ST_SGO:   st_d.state = ST_SWAIT;
            ST_SWAIT: begin
                if (mul_done_i) begin
                    st_d.sq = mul_prod_i;
                    if (st_q.bitc == CW'(W - 1)) begin
                        st_d.state = ST_IDLE;
                        st_d.done  = 1'b1;
                        st_d.out   = st_q.res;
                    end else begin
                        st_d.bitc  = st_q.bitc + 1'b1;
                        st_d.e     = e_next;
                        st_d.state = e_next[0] ? ST_RGO : ST_SGO;
                    end
                end
            end
            default:  st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.out;
    assign done_o   = st_q.done;

    // R2: completion is a one-cycle pulse.
    assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7: the visible result only moves together with the done pulse.
    assert_result_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

    // R3: the running square stays reduced while a job is active.
    assert_square_below_mod_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state != ST_IDLE) |-> (st_q.sq < st_q.n));

    // R6: the captured modulus is frozen while a job runs.
    assert_modulus_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.state != ST_IDLE) && ($past(st_q.state) != ST_IDLE)) |-> $stable(st_q.n));

endmodule

// File: rtl/modexp_rl.sv
module modexp_rl #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] exp_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] result_o,
    output logic         done_o
);

    logic         mul_start;
    logic         mul_done;
    logic [W-1:0] mul_x, mul_y, mul_m, mul_prod;

    modexp_seq #(.W(W)) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .base_i     (base_i),
        .exp_i      (exp_i),
        .mod_i      (mod_i),
        .mul_start_o(mul_start),
        .mul_x_o    (mul_x),
        .mul_y_o    (mul_y),
        .mul_m_o    (mul_m),
        .mul_done_i (mul_done),
        .mul_prod_i (mul_prod),
        .result_o   (result_o),
        .done_o     (done_o)
    );

    modexp_mul #(.W(W)) u_mul (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(mul_start),
        .x_i    (mul_x),
        .y_i    (mul_y),
        .m_i    (mul_m),
        .done_o (mul_done),
        .prod_o (mul_prod)
    );

endmodule

// File: tb/modexp_rl_tb.sv
module modexp_rl_tb;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [31:0] exp_i = '0;
    logic [31:0] mod_i = 32'd2;
    logic [31:0] result_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_tag = "R1";

    // reference model state
    int          m_cnt = 0;
    logic        m_done = 1'b0;
    logic [31:0] m_res = '0;
    logic [31:0] m_pend = '0;

    always #2 clk_i = ~clk_i;  // 250 MHz

    modexp_rl u_dut (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .base_i  (base_i),
        .exp_i   (exp_i),
        .mod_i   (mod_i),
        .result_o(result_o),
        .done_o  (done_o)
    );

    function automatic logic [31:0] ref_pow(input logic [31:0] b, input logic [31:0] e,
                                            input logic [31:0] n);
        longint unsigned r = 1;
        longint unsigned bb = b;
        longint unsigned nn = n;
        for (int i = 31; i >= 0; i--) begin
            r = (r * r) % nn;
            if (e[i]) r = (r * bb) % nn;
        end
        return r[31:0];
    endfunction

    // cycle model: idle when m_cnt == 0
    always @(posedge clk_i) begin
        cycles++;
        m_done = 1'b0;
        if (!rst_ni) begin
            m_cnt = 0;
            m_res = '0;
        end else if (m_cnt == 0) begin
            if (start_i) begin
                m_cnt  = 34 * (32 + $countones(exp_i));
                m_pend = ref_pow(base_i, exp_i, mod_i);
            end
        end else begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_done = 1'b1;
                m_res  = m_pend;
            end
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk_i) begin
        n_checks++;
        if (done_o !== m_done) begin
            n_fail++;
            $display("FAIL R2 done_o actual=%0b expected=%0b cycle=%0d", done_o, m_done, cycles);
        end
        n_checks++;
        if (result_o !== m_res) begin
            n_fail++;
            $display("FAIL %s result_o actual=%h expected=%h cycle=%0d",
                     (m_done ? cur_tag : "R7"), result_o, m_res, cycles);
        end
    end

    always @(posedge clk_i) begin
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
            $finish;
        end
    end

    task automatic pulse(input logic [31:0] b, input logic [31:0] e, input logic [31:0] n);
        base_i  = b;
        exp_i   = e;
        mod_i   = n;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk_i); while (m_cnt != 0);
        @(negedge clk_i);
    endtask

    task automatic run(input string tag, input logic [31:0] b, input logic [31:0] e,
                       input logic [31:0] n);
        cur_tag = tag;
        @(negedge clk_i);
        pulse(b, e, n);
        wait_done();
    endtask

    initial begin
        repeat (4) @(negedge clk_i);  // R1 checked in reset
        rst_ni = 1'b1;
        repeat (4) @(negedge clk_i);  // R1 idle after release

        run("R4", 32'd5, 32'd0, 32'd13);
        run("R5", 32'd7, 32'd2, 32'd101);
        run("R3", 32'd3, 32'd1, 32'd1000);
        run("R3", 32'd2, 32'd1000000006, 32'd1000000007);
        run("R8", 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'hFFFF_FFFB);
        run("R3", 32'd0, 32'd5, 32'd17);
        run("R3", 32'd96, 32'd3, 32'd97);
        run("R3", 32'd1, 32'd7, 32'd2);
        run("R3", 32'd12345, 32'h8000_0000, 32'd65537);
        run("R5", 32'hFFFF_FFFA, 32'd2, 32'hFFFF_FFFB);

        // R6: second request lands mid-job and is ignored
        cur_tag = "R6";
        @(negedge clk_i);
        pulse(32'd11, 32'd77, 32'd1009);
        repeat (100) @(negedge clk_i);
        pulse(32'd3, 32'd5, 32'd7);
        wait_done();
        repeat (3) @(negedge clk_i);

        // R9: new request issued in the done cycle
        cur_tag = "R9";
        pulse(32'd9, 32'd13, 32'd31);
        do @(negedge clk_i); while (m_cnt != 0);
        pulse(32'd6, 32'd21, 32'd55);
        wait_done();
        repeat (3) @(negedge clk_i);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule